// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block is the bus side of a processor front end. While the execution side is busy, it reads instruction words ahead of need into a six-byte first-in first-out queue. The consumer takes bytes one at a time from the head of the queue. The block shares one 16-bit memory bus between two kinds of traffic: these prefetch reads, and operand reads and writes to memory or I/O that the execution side requests. Every bus address is 20 bits wide. It is built from a 16-bit segment and a 16-bit offset.

A jump is handled with a flush. The flush empties the queue and loads a new code segment and instruction pointer. A bus cycle that is already running is allowed to finish, but the bytes it returns are thrown away. The queue then refills from the new location. A misaligned (odd) target costs nothing extra: the first fetch reads the aligned word and keeps only its upper byte.

Top module: `pfq_biu`

## Requirements
- R1: The queue holds up to 6 bytes and hands them out in the order they were fetched. `qByte` shows the head byte whenever `qValid` is high, and a cycle with `qTake` high removes that byte.
- R2: A prefetch cycle begins only from the idle bus, only when at least 2 queue slots are free, and only when `opReq` is low. With 6 bytes queued and no operand request, the bus stays idle.
- R3: Each prefetch reads one word at an even address. With an even instruction pointer, the low byte (bits 7:0) is queued first, then the high byte (bits 15:8), and the pointer advances by 2.
- R4: With an odd instruction pointer, the fetch reads the word at the pointer with bit 0 cleared, queues only bits 15:8, and advances the pointer by 1. Every later fetch is at an even address.
- R5: The bus address is (segment × 16 + offset) modulo 2^20. Fetches use the code segment and the instruction pointer, and the pointer wraps at 16 bits.
- R6: A bus cycle keeps `busReq`, `busAddr`, `busWrite` and `busIo` unchanged until `busReady` is seen at a clock edge. Read data is captured at that same edge, and for an operand cycle `opDone` is high for exactly the next cycle, with `opRdata` valid.
- R7: An operand request that arrives during a prefetch cycle waits until that fetch has completed. From the idle bus, an operand request is served before any prefetch.
- R8: During a bus cycle exactly one of `memRd`, `memWr`, `ioRd`, `ioWr` is high, matching the cycle type, and prefetches always use `memRd`. All four are low when the bus is idle.
- R9: A `flushReq` cycle empties the queue and loads `flushSeg`/`flushOff` as the new code segment and instruction pointer. A bus cycle in flight is not aborted, its fetched bytes are dropped, and the next fetch uses the new address.
- R10: During reset and after it, the queue is empty and no bus cycle is requested. The code segment resets to 16'hFFFF and the pointer to 16'h0000, so the first fetch is at 20'hFFFF0.
- R11: `qTake` while the queue is empty has no effect: no later byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qByte | output | 8 | Head byte of the queue |
| qValid | output | 1 | Queue holds at least one byte |
| qTake | input | 1 | Remove the head byte |
| flushReq | input | 1 | Empty the queue and load a new fetch location |
| flushSeg | input | 16 | New code segment |
| flushOff | input | 16 | New instruction pointer |
| opReq | input | 1 | Operand access request, held until opDone |
| opWrite | input | 1 | Operand access is a write |
| opIo | input | 1 | Operand access targets I/O space |
| opSeg | input | 16 | Operand segment |
| opOff | input | 16 | Operand offset |
| opWdata | input | 16 | Operand write data |
| opRdata | output | 16 | Operand read data |
| opDone | output | 1 | One-cycle operand completion pulse |
| busReq | output | 1 | Bus cycle active |
| busAddr | output | 20 | Physical bus address |
| busWrite | output | 1 | Cycle is a write |
| busIo | output | 1 | Cycle targets I/O space |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data |
| busReady | input | 1 | Cycle completes at this edge |
| memRd | output | 1 | Memory read cycle |
| memWr | output | 1 | Memory write cycle |
| ioRd | output | 1 | I/O read cycle |
| ioWr | output | 1 | I/O write cycle |

## Verification
The checker watches these points on every cycle:
- the queue never goes past its depth;
- a fetch never starts with fewer than two free slots or with an operand request pending;
- no fetch runs with a full queue;
- fetch addresses are even;
- address and control stay unchanged through wait states;
- a started fetch is never abandoned;
- the strobes are one-hot and a fetch always uses `memRd`;
- `opDone` follows a completed operand cycle as a single pulse.

Only the bench scenarios can show the rest: byte values and their order, address arithmetic including the 20-bit wrap, the odd-target entry, the dropping of bytes from a cycle in flight at a flush, an operand read being served after the fetch it collided with, and a take on an empty queue losing nothing.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int SEG_W  = 16;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic startFetch;
    logic startOp;
    logic fetchDone;
    logic dropFetch;
    logic opCapture;
    logic flush;
  } pfqStrobes_t;

  function automatic logic [ADDR_W-1:0] physAddr(input logic [SEG_W-1:0] seg,
                                                 input logic [SEG_W-1:0] off);
    logic [ADDR_W-1:0] segShift;
    segShift = {seg, 4'b0000};
    return segShift + ADDR_W'(off);
  endfunction
endpackage

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  pfqStrobes_t         strb,
  input  logic                qTake,
  input  logic [SEG_W-1:0]    flushSeg,
  input  logic [SEG_W-1:0]    flushOff,
  input  logic                opWrite,
  input  logic                opIo,
  input  logic [SEG_W-1:0]    opSeg,
  input  logic [SEG_W-1:0]    opOff,
  input  logic [WORD_W-1:0]   opWdata,
  input  logic [WORD_W-1:0]   busRdata,
  output logic [7:0]          qByte,
  output logic                qValid,
  output logic [CNT_W-1:0]    qCount,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busWrite,
  output logic                busIo,
  output logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   opRdata
);
  logic [DEPTH-1:0][7:0] slot;
  logic [DEPTH-1:0][7:0] slotNext;
  logic [SEG_W-1:0]      csReg;
  logic [SEG_W-1:0]      ipReg;
  logic                  popEn;
  logic                  pushEn;
  logic [1:0]            pushN;
  logic [7:0]            pushLo;
  logic [CNT_W-1:0]      afterPop;
  logic [CNT_W-1:0]      afterPopNext;
  logic [CNT_W-1:0]      countNext;
  logic [ADDR_W-1:0]     fetchPhys;

  assign popEn        = qTake && (qCount != '0) && !strb.flush;
  assign pushEn       = strb.fetchDone && !strb.dropFetch;
  assign pushN        = pushEn ? (ipReg[0] ? 2'd1 : 2'd2) : 2'd0;
  assign pushLo       = ipReg[0] ? busRdata[15:8] : busRdata[7:0];
  assign afterPop     = qCount - CNT_W'(popEn);
  assign afterPopNext = afterPop + CNT_W'(1);
  assign countNext    = strb.flush ? '0 : afterPop + CNT_W'(pushN);
  assign fetchPhys    = physAddr(csReg, ipReg);

  // each slot either shifts toward the head, takes a pushed byte, or holds
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [7:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = popEn ? slot[i+1] : slot[i];
    end else begin : g_last
      assign shifted = slot[i];
    end
    assign slotNext[i] =
      (pushEn && afterPop == CNT_W'(i))                       ? pushLo :
      (pushEn && pushN == 2'd2 && afterPopNext == CNT_W'(i))  ? busRdata[15:8] :
                                                                shifted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot     <= '0;
      qCount   <= '0;
      csReg    <= RESET_SEG;
      ipReg    <= RESET_OFF;
      busAddr  <= '0;
      busWrite <= 1'b0;
      busIo    <= 1'b0;
      busWdata <= '0;
      opRdata  <= '0;
    end else begin
      slot   <= slotNext;
      qCount <= countNext;
      if (strb.flush) begin
        csReg <= flushSeg;
        ipReg <= flushOff;
      end else if (pushEn) begin
        ipReg <= ipReg + SEG_W'(pushN);
      end
      if (strb.startFetch) begin
        busAddr  <= {fetchPhys[ADDR_W-1:1], 1'b0};
        busWrite <= 1'b0;
        busIo    <= 1'b0;
      end else if (strb.startOp) begin
        busAddr  <= physAddr(opSeg, opOff);
        busWrite <= opWrite;
        busIo    <= opIo;
        busWdata <= opWdata;
      end
      if (strb.opCapture) opRdata <= busRdata;
    end
  end

  assign qByte  = slot[0];
  assign qValid = (qCount != '0);
endmodule

// File: rtl/pfq_control.sv
module pfq_control
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opReq,
  input  logic             flushReq,
  input  logic             busReady,
  input  logic [CNT_W-1:0] qCount,
  output pfqStrobes_t      strb,
  output logic             busReq,
  output logic             fetchActive,
  output logic             opActive,
  output logic             opDone
);
  typedef enum logic [1:0] { ST_IDLE, ST_FETCH, ST_OPER } busState_t;

  busState_t state;
  busState_t stateNext;
  logic      stale;
  logic      roomForWord;
  logic      canOp;
  logic      canFetch;

  assign roomForWord = (qCount <= CNT_W'(DEPTH - 2));
  // opDone high means the requester has not yet dropped opReq
  assign canOp    = (state == ST_IDLE) && opReq && !opDone;
  assign canFetch = (state == ST_IDLE) && !opReq && roomForWord && !flushReq;

  always_comb begin
    strb            = '0;
    strb.startOp    = canOp;
    strb.startFetch = canFetch;
    strb.fetchDone  = (state == ST_FETCH) && busReady;
    strb.dropFetch  = stale || flushReq;
    strb.opCapture  = (state == ST_OPER) && busReady;
    strb.flush      = flushReq;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (canOp) stateNext = ST_OPER;
                else if (canFetch) stateNext = ST_FETCH;
      ST_FETCH: if (busReady) stateNext = ST_IDLE;
      ST_OPER:  if (busReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      stale  <= 1'b0;
      opDone <= 1'b0;
    end else begin
      state  <= stateNext;
      opDone <= strb.opCapture;
      if (state == ST_FETCH && busReady) stale <= 1'b0;
      else if (state == ST_FETCH && flushReq) stale <= 1'b1;
    end
  end

  assign busReq      = (state != ST_IDLE);
  assign fetchActive = (state == ST_FETCH);
  assign opActive    = (state == ST_OPER);
endmodule

// File: rtl/pfq_biu.sv
module pfq_biu
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [7:0]  qByte,
  output logic        qValid,
  input  logic        qTake,
  input  logic        flushReq,
  input  logic [15:0] flushSeg,
  input  logic [15:0] flushOff,
  input  logic        opReq,
  input  logic        opWrite,
  input  logic        opIo,
  input  logic [15:0] opSeg,
  input  logic [15:0] opOff,
  input  logic [15:0] opWdata,
  output logic [15:0] opRdata,
  output logic        opDone,
  output logic        busReq,
  output logic [19:0] busAddr,
  output logic        busWrite,
  output logic        busIo,
  output logic [15:0] busWdata,
  input  logic [15:0] busRdata,
  input  logic        busReady,
  output logic        memRd,
  output logic        memWr,
  output logic        ioRd,
  output logic        ioWr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  pfqStrobes_t      strb;
  logic [CNT_W-1:0] qCount;
  logic             fetchActive;
  logic             opActive;

  pfq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .opReq(opReq), .flushReq(flushReq),
    .busReady(busReady), .qCount(qCount), .strb(strb), .busReq(busReq),
    .fetchActive(fetchActive), .opActive(opActive), .opDone(opDone)
  );

  pfq_datapath #(.DEPTH(DEPTH), .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qTake(qTake),
    .flushSeg(flushSeg), .flushOff(flushOff), .opWrite(opWrite), .opIo(opIo),
    .opSeg(opSeg), .opOff(opOff), .opWdata(opWdata), .busRdata(busRdata),
    .qByte(qByte), .qValid(qValid), .qCount(qCount), .busAddr(busAddr),
    .busWrite(busWrite), .busIo(busIo), .busWdata(busWdata), .opRdata(opRdata)
  );

  assign memRd = busReq && !busIo && !busWrite;
  assign memWr = busReq && !busIo &&  busWrite;
  assign ioRd  = busReq &&  busIo && !busWrite;
  assign ioWr  = busReq &&  busIo &&  busWrite;
endmodule

// File: rtl/pfq_biu_checker.sv
module pfq_biu_checker #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busReady,
  input logic [19:0]      busAddr,
  input logic             busWrite,
  input logic             busIo,
  input logic             memRd,
  input logic             memWr,
  input logic             ioRd,
  input logic             ioWr,
  input logic [CNT_W-1:0] qCount,
  input logic             fetchActive,
  input logic             opActive,
  input logic             opReq,
  input logic             opDone
);
  assert_depth_R1: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH));

  assert_fetch_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchActive) |-> ($past(qCount) <= CNT_W'(DEPTH - 2)) && !$past(opReq));

  assert_full_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == CNT_W'(DEPTH)) |-> !fetchActive);

  assert_fetch_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchActive |-> !busAddr[0]);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> busReq && $stable(busAddr) && $stable(busWrite) && $stable(busIo));

  assert_done_after_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opActive && busReady) |=> opDone);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  assert_fetch_finishes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchActive && !busReady) |=> fetchActive);

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr}));

  assert_fetch_memrd_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchActive |-> memRd);
endmodule

bind pfq_biu pfq_biu_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busReady(busReady), .busAddr(busAddr),
  .busWrite(busWrite), .busIo(busIo), .memRd(memRd), .memWr(memWr), .ioRd(ioRd),
  .ioWr(ioWr), .qCount(qCount), .fetchActive(fetchActive), .opActive(opActive),
  .opReq(opReq), .opDone(opDone)
);

// File: tb/pfq_biu_tb.sv
module pfq_biu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  qByte;
  logic        qValid;
  logic        qTake = 1'b0;
  logic        flushReq = 1'b0;
  logic [15:0] flushSeg = '0, flushOff = '0;
  logic        opReq = 1'b0, opWrite = 1'b0, opIo = 1'b0;
  logic [15:0] opSeg = '0, opOff = '0, opWdata = '0;
  logic [15:0] opRdata;
  logic        opDone, busReq, busWrite, busIo;
  logic [19:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        memRd, memWr, ioRd, ioWr;

  int total = 0;
  int failed = 0;
  int waitCycles = 0;
  int waitCnt = 0;
  int logN = 0;
  logic [19:0] logAddr [256];
  logic [3:0]  logCtl  [256];
  logic [15:0] logWd   [256];

  always #5 clk = ~clk;

  pfq_biu u_dut (.*);

  function automatic logic [7:0] byteAt(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction
  function automatic logic [15:0] wordAt(input logic [19:0] a);
    return {byteAt({a[19:1], 1'b1}), byteAt({a[19:1], 1'b0})};
  endfunction
  function automatic logic [19:0] physOf(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'b0000} + {4'b0000, o};
  endfunction

  // bus responder: inputs change on the falling edge
  always @(negedge clk) begin
    if (busReq && !busReady) begin
      if (waitCnt >= waitCycles) begin
        busReady <= 1'b1;
        busRdata <= busIo ? ~wordAt(busAddr) : wordAt(busAddr);
        waitCnt  <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      busReady <= 1'b0;
    end
  end

  // log every completed bus cycle
  always @(posedge clk) begin
    if (rstN && busReq && busReady && logN < 256) begin
      logAddr[logN] = busAddr;
      logCtl[logN]  = {memRd, memWr, ioRd, ioWr};
      logWd[logN]   = busWdata;
      logN = logN + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doFlush(input logic [15:0] s, input logic [15:0] o);
    flushSeg = s; flushOff = o; flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
  endtask

  task automatic waitFullIdle();
    int g = 0;
    repeat (40) @(negedge clk);
    while (busReq && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic popStream(input logic [15:0] s, input logic [15:0] o, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int g = 0;
      logic [7:0] exp;
      while (!qValid && g < 300) begin @(negedge clk); g++; end
      exp = byteAt(physOf(s, o + 16'(k)));
      check(qValid && qByte == exp, tag, {24'h0, qByte}, {24'h0, exp});
      qTake = 1'b1;
      @(negedge clk);
      qTake = 1'b0;
    end
  endtask

  task automatic doOp(input logic w, input logic io, input logic [15:0] s,
                      input logic [15:0] o, input logic [15:0] wd);
    int g = 0;
    opWrite = w; opIo = io; opSeg = s; opOff = o; opWdata = wd; opReq = 1'b1;
    @(negedge clk);
    while (!opDone && g < 300) begin @(negedge clk); g++; end
    opReq = 1'b0;
  endtask

  task automatic t_reset();
    int g = 0;
    repeat (3) @(negedge clk);
    check(!qValid, "R10 queue empty in reset", {31'h0, qValid}, 32'h0);
    check(!busReq, "R10 no bus cycle in reset", {31'h0, busReq}, 32'h0);
    rstN = 1'b1;
    while (logN == 0 && g < 100) begin @(negedge clk); g++; end
    check(logAddr[0] == 20'hFFFF0, "R10 R5 first fetch address", {12'h0, logAddr[0]}, 32'hFFFF0);
    check(logCtl[0] == 4'b1000, "R8 fetch uses memRd", {28'h0, logCtl[0]}, 32'h8);
  endtask

  task automatic t_fillIdle();
    int seen;
    waitFullIdle();
    seen = logN;
    check(seen == 3, "R2 R3 six bytes take three fetches", seen, 3);
    repeat (30) @(negedge clk);
    check(logN == seen && !busReq, "R2 bus idle with full queue", logN, seen);
  endtask

  task automatic t_stream();
    // crosses the 20-bit wrap at offset 16'h0010
    popStream(16'hFFFF, 16'h0000, 20, "R1 R3 R5 byte order");
  endtask

  task automatic t_odd();
    int base;
    waitFullIdle();
    base = logN;
    doFlush(16'h1234, 16'h0101);
    popStream(16'h1234, 16'h0101, 5, "R4 odd target stream");
    check(logAddr[base] == 20'h12440, "R4 aligned first fetch", {12'h0, logAddr[base]}, 32'h12440);
    check(logAddr[base+1] == 20'h12442, "R4 next fetch even", {12'h0, logAddr[base+1]}, 32'h12442);
  endtask

  task automatic t_flushInflight();
    int g = 0;
    int base;
    logic [19:0] oldAddr;
    waitCycles = 6;
    waitFullIdle();
    doFlush(16'h0500, 16'h0000);
    while (!busReq && g < 50) begin @(negedge clk); g++; end
    oldAddr = busAddr;
    base = logN;
    doFlush(16'h0A00, 16'h0004);
    check(busReq && busAddr == oldAddr, "R9 in-flight cycle kept", {12'h0, busAddr}, {12'h0, oldAddr});
    popStream(16'h0A00, 16'h0004, 6, "R9 stale bytes dropped");
    check(logAddr[base] == oldAddr, "R9 old cycle completes", {12'h0, logAddr[base]}, {12'h0, oldAddr});
    check(logAddr[base+1] == 20'h0A004, "R9 refetch from new target", {12'h0, logAddr[base+1]}, 32'h0A004);
  endtask

  task automatic t_opWait();
    int g = 0;
    int base;
    waitCycles = 3;
    waitFullIdle();
    doFlush(16'h0600, 16'h0000);
    while (!busReq && g < 50) begin @(negedge clk); g++; end
    base = logN;
    doOp(1'b0, 1'b0, 16'h2000, 16'h0010, 16'h0);
    check(logAddr[base] == 20'h06000, "R7 fetch finishes first", {12'h0, logAddr[base]}, 32'h06000);
    check(logAddr[base+1] == 20'h20010, "R7 R5 operand follows", {12'h0, logAddr[base+1]}, 32'h20010);
    check(logCtl[base+1] == 4'b1000, "R8 memory read strobe", {28'h0, logCtl[base+1]}, 32'h8);
    check(opRdata == wordAt(20'h20010), "R6 read data captured", {16'h0, opRdata}, {16'h0, wordAt(20'h20010)});
    @(negedge clk);
    check(!opDone, "R6 opDone single pulse", {31'h0, opDone}, 32'h0);
  endtask

  task automatic t_opKinds();
    int base;
    waitCycles = 1;
    waitFullIdle();
    base = logN;
    doOp(1'b1, 1'b1, 16'hFFFF, 16'h0020, 16'hBEEF);
    check(logAddr[base] == 20'h00010, "R5 operand address wraps", {12'h0, logAddr[base]}, 32'h00010);
    check(logCtl[base] == 4'b0001 && logWd[base] == 16'hBEEF, "R8 io write", {12'h0, logCtl[base], logWd[base]}, {12'h0, 4'b0001, 16'hBEEF});
    doOp(1'b0, 1'b1, 16'h0000, 16'h0300, 16'h0);
    check(logCtl[base+1] == 4'b0010, "R8 io read strobe", {28'h0, logCtl[base+1]}, 32'h2);
    check(opRdata == ~wordAt(20'h00300), "R6 io read data", {16'h0, opRdata}, {16'h0, ~wordAt(20'h00300)});
    doOp(1'b1, 1'b0, 16'h0100, 16'h0002, 16'h1234);
    check(logCtl[base+2] == 4'b0100 && logAddr[base+2] == 20'h01002, "R8 memory write", {8'h0, logCtl[base+2], logAddr[base+2]}, {8'h0, 4'b0100, 20'h01002});
  endtask

  task automatic t_takeEmpty();
    waitCycles = 4;
    waitFullIdle();
    doFlush(16'h0700, 16'h0002);
    check(!qValid, "R9 flush empties queue", {31'h0, qValid}, 32'h0);
    qTake = 1'b1;
    repeat (3) @(negedge clk);
    qTake = 1'b0;
    popStream(16'h0700, 16'h0002, 4, "R11 take on empty ignored");
  endtask

  initial begin
    t_reset();
    t_fillIdle();
    t_stream();
    t_odd();
    t_flushInflight();
    t_opWait();
    t_opKinds();
    t_takeEmpty();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule